// File: doc/BRIEF.md
# Maskable Interrupt Controller with Delayed Request Line

This block gathers single-cycle event strobes from neighbouring peripherals into a sticky pending-flag register. The flags are gated by an enable mask, and the block drives an active-low interrupt request toward a processor. The request goes low a fixed number of clocks after an enabled event is latched. The default is one clock, which gives a pipelined assertion rather than an immediate one.

Software controls the mask through one write port. Bit 7 of the written byte selects the action: when it is set, the 1 bits of the byte are added to the mask; when it is clear, the 1 bits are removed from it.

The status word is always visible on the read data port. A read strobe consumes it. On that edge it clears every flag, cancels any request still in the delay pipeline and returns the request line high. Enabling a bit whose flag is already pending starts the same delayed assertion that a fresh event would start. The timers, the alarm logic and the edge detector that produce the strobes sit outside this block.

Top module: `irq_gate_ctrl`

## Requirements
- R1: The status word holds the timer A event in bit 0, the timer B event in bit 1, the alarm event in bit 2 and the edge event in bit 4. Bits 3, 5 and 6 always read 0.
- R2: An event strobe sets its flag whether or not its mask bit is enabled. The flag stays set until a status read. Events whose mask bit is disabled never pull the request line low.
- R3: A mask write with bit 7 = 1 sets the mask bits given by the 1 bits of data bits 4..0. With bit 7 = 0 it clears those mask bits. All other mask bits are unchanged. For example, writing 0x83 and then 0x02 leaves only bit 0 enabled.
- R4: An event whose mask bit is enabled is latched on the clock edge that ends its strobe cycle. The request line goes low on the next edge after that one.
- R5: A mask write that enables a bit whose flag is already pending pulls the request line low on the second edge after the write strobe cycle.
- R6: Status bit 7 reads 1 exactly when some pending flag has its mask bit enabled.
- R7: A read strobe returns the current status. On that edge it clears all flags, cancels any delayed assertion still in flight and drives the request line high.
- R8: An event strobed in the same cycle as a read is kept as a new flag after the clear. If its mask bit is enabled, it starts a new delayed assertion.
- R9: When a read and a mask write fall in the same cycle, the mask is updated, but flags that the read clears do not start an assertion.
- R10: After reset the status reads 0x00, the mask is empty and the request line is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tmr_a_evt | input | 1 | Timer A underflow strobe, one cycle |
| tmr_b_evt | input | 1 | Timer B underflow strobe, one cycle |
| alarm_evt | input | 1 | Alarm match strobe, one cycle |
| edge_evt | input | 1 | Falling-edge strobe from the external flag input |
| rd_stb | input | 1 | Status read strobe; clears flags at the clock edge |
| wr_stb | input | 1 | Mask write strobe |
| wr_data | input | DATA_W | Mask write value; bit 7 selects set or clear |
| rd_data | output | DATA_W | Status word: flags in the low bits, summary in bit 7 |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit data word, five flag positions and a one-stage request delay. With a single delay stage, every corner of the pipeline can be reached from one cycle's stimulus. These corners are a read landing in the cycle between latching and assertion, an event coincident with a read, and a read coincident with a mask write. The bench observes each of them at the request line and the status word in a known cycle.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned BIT_TMR_A = 0;
  localparam int unsigned BIT_TMR_B = 1;
  localparam int unsigned BIT_ALARM = 2;
  localparam int unsigned BIT_EDGE  = 4;
  localparam int unsigned MIN_SRC_W = 5;
endpackage

// File: rtl/irqc_flag_reg.sv
module irqc_flag_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] flags_o
);
  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;
  logic         flags_en;

  always_comb begin
    flags_en = clr_i | (|set_i);
    if (clr_i) flags_d = set_i;
    else       flags_d = flags_q | set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int unsigned W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic         set_mode_i,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] mask_next_o
);
  logic [W-1:0] mask_q;
  logic [W-1:0] mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_i) begin
      if (set_mode_i) mask_d = mask_q | bits_i;
      else            mask_d = mask_q & ~bits_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    mask_q <= '0;
    else if (wr_i) mask_q <= mask_d;
  end

  assign mask_o      = mask_q;
  assign mask_next_o = mask_d;
endmodule

// File: rtl/irqc_line_delay.sv
module irqc_line_delay #(
  parameter int unsigned LAT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  input  logic cancel_i,
  output logic irq_n_o
);
  logic [LAT-1:0] stage_q;
  logic [LAT-1:0] stage_d;
  logic           irq_n_q;
  logic           irq_n_d;
  logic           irq_en;

  generate
    if (LAT == 1) begin : g_single
      always_comb stage_d = trig_i;
    end else begin : g_chain
      always_comb begin
        if (cancel_i) stage_d = {{(LAT-1){1'b0}}, trig_i};
        else          stage_d = {stage_q[LAT-2:0], trig_i};
      end
    end
  endgenerate

  always_comb begin
    irq_en  = cancel_i | stage_q[LAT-1];
    irq_n_d = cancel_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= '0;
    else        stage_q <= stage_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_n_q <= 1'b1;
    else if (irq_en) irq_n_q <= irq_n_d;
  end

  assign irq_n_o = irq_n_q;
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SRC_W  = 5,
  parameter int unsigned LAT    = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_a_evt,
  input  logic              tmr_b_evt,
  input  logic              alarm_evt,
  input  logic              edge_evt,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq_n
);
  import irqc_pkg::*;

  localparam int unsigned SUM_BIT = DATA_W - 1;
  localparam int unsigned PAD_W   = DATA_W - 1 - SRC_W;

  logic [1:0]       rst_sync_q;
  logic             rst_sync_n;
  logic [SRC_W-1:0] ev_vec;
  logic [SRC_W-1:0] flags_q;
  logic [SRC_W-1:0] mask_q;
  logic [SRC_W-1:0] mask_d;
  logic             ev_trig;
  logic             wr_trig;
  logic             trig;
  logic             any_hit;
  logic [PAD_W-1:0] unused_wr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  always_comb begin
    ev_vec            = '0;
    ev_vec[BIT_TMR_A] = tmr_a_evt;
    ev_vec[BIT_TMR_B] = tmr_b_evt;
    ev_vec[BIT_ALARM] = alarm_evt;
    ev_vec[BIT_EDGE]  = edge_evt;
  end

  irqc_flag_reg #(.W(SRC_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (ev_vec),
    .clr_i   (rd_stb),
    .flags_o (flags_q)
  );

  irqc_mask_reg #(.W(SRC_W)) u_mask (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_i        (wr_stb),
    .set_mode_i  (wr_data[SUM_BIT]),
    .bits_i      (wr_data[SRC_W-1:0]),
    .mask_o      (mask_q),
    .mask_next_o (mask_d)
  );

  always_comb begin
    ev_trig = |(ev_vec & mask_d);
    wr_trig = wr_stb & ~rd_stb & (|(flags_q & mask_d));
    trig    = ev_trig | wr_trig;
    any_hit = |(flags_q & mask_q);
  end

  irqc_line_delay #(.LAT(LAT)) u_line (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .trig_i   (trig),
    .cancel_i (rd_stb),
    .irq_n_o  (irq_n)
  );

  assign unused_wr_bits = wr_data[SUM_BIT-1:SRC_W];
  assign rd_data        = {any_hit, {PAD_W{1'b0}}, flags_q};
endmodule

// File: rtl/irq_gate_ctrl_chk.sv
module irq_gate_ctrl_chk #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned SRC_W  = 5
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              rd_stb,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic [SRC_W-1:0]  flags_q,
  input logic [SRC_W-1:0]  mask_q,
  input logic              irq_n
);
  // R7: a read always leaves the line released
  a_r7_read_releases: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rd_stb |=> irq_n);

  // R2: flags only drop on a read
  a_r2_flags_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_stb |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R3: set-mode write
  a_r3_mask_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb && wr_data[DATA_W-1]) |=>
      ((mask_q & $past(wr_data[SRC_W-1:0])) == $past(wr_data[SRC_W-1:0])));

  // R3: clear-mode write
  a_r3_mask_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_stb && !wr_data[DATA_W-1]) |=> ((mask_q & $past(wr_data[SRC_W-1:0])) == '0));

  // R4: the line only falls while some flag is pending
  a_r4_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(irq_n) |-> ($past(|flags_q) && !$past(rd_stb)));
endmodule

bind irq_gate_ctrl irq_gate_ctrl_chk #(.DATA_W(DATA_W), .SRC_W(SRC_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .rd_stb     (rd_stb),
  .wr_stb     (wr_stb),
  .wr_data    (wr_data),
  .flags_q    (flags_q),
  .mask_q     (mask_q),
  .irq_n      (irq_n)
);

// File: tb/sim_irq_gate_ctrl.sv
`timescale 1ns/1ps
module sim_irq_gate_ctrl;
  logic       clk;
  logic       rst_n;
  logic       tmr_a_evt, tmr_b_evt, alarm_evt, edge_evt;
  logic       rd_stb, wr_stb;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       irq_n;
  int         n_chk;
  int         n_bad;
  logic       done;

  irq_gate_ctrl u0 (
    .clk(clk), .rst_n(rst_n),
    .tmr_a_evt(tmr_a_evt), .tmr_b_evt(tmr_b_evt),
    .alarm_evt(alarm_evt), .edge_evt(edge_evt),
    .rd_stb(rd_stb), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_data(rd_data), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk8(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic chk1(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic mask_write(input logic [7:0] d);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0; wr_data = 8'h00;
  endtask

  task automatic pulse(input logic a, input logic b, input logic al, input logic e);
    tmr_a_evt = a; tmr_b_evt = b; alarm_evt = al; edge_evt = e;
    @(negedge clk);
    tmr_a_evt = 0; tmr_b_evt = 0; alarm_evt = 0; edge_evt = 0;
  endtask

  task automatic do_read(output logic [7:0] v);
    rd_stb = 1'b1;
    #1 v = rd_data;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic t_reset;
    chk8("R10 status after reset", rd_data, 8'h00);
    chk1("R10 line after reset", irq_n, 1'b1);
  endtask

  task automatic t_unmasked;
    logic [7:0] v;
    pulse(1, 1, 1, 1);
    chk8("R1 all sources map", rd_data, 8'h17);
    @(negedge clk);
    chk1("R2 unmasked events keep line high", irq_n, 1'b1);
    @(negedge clk);
    chk8("R2 flags persist", rd_data, 8'h17);
    do_read(v);
    chk8("R7 read returns flags", v, 8'h17);
    chk8("R7 flags cleared", rd_data, 8'h00);
  endtask

  task automatic t_delay;
    logic [7:0] v;
    mask_write(8'h81);
    pulse(1, 0, 0, 0);
    chk1("R4 line high in the latch cycle", irq_n, 1'b1);
    @(negedge clk);
    chk1("R4 line low one clock later", irq_n, 1'b0);
    chk8("R6 summary bit set", rd_data, 8'h81);
    do_read(v);
    chk8("R7 read value", v, 8'h81);
    chk1("R7 line released", irq_n, 1'b1);
    chk8("R7 cleared", rd_data, 8'h00);
  endtask

  task automatic t_cancel;
    logic [7:0] v;
    pulse(1, 0, 0, 0);
    do_read(v);
    chk8("R7 read during delay", v, 8'h81);
    chk1("R7 pending assertion cancelled", irq_n, 1'b1);
    @(negedge clk);
    chk1("R7 still released", irq_n, 1'b1);
  endtask

  task automatic t_same_rd_wr;
    logic [7:0] v;
    mask_write(8'h7F);
    pulse(1, 0, 0, 0);
    rd_stb = 1'b1; wr_stb = 1'b1; wr_data = 8'h81;
    #1 v = rd_data;
    chk8("R9 read value", v, 8'h01);
    @(negedge clk);
    rd_stb = 1'b0; wr_stb = 1'b0; wr_data = 8'h00;
    chk8("R9 flags cleared", rd_data, 8'h00);
    @(negedge clk);
    chk1("R9 no assertion from cleared flags", irq_n, 1'b1);
    pulse(1, 0, 0, 0);
    @(negedge clk);
    chk1("R9 mask still updated", irq_n, 1'b0);
    do_read(v);
  endtask

  task automatic t_mask_seq;
    logic [7:0] v;
    mask_write(8'h7F);
    mask_write(8'h83);
    mask_write(8'h02);
    pulse(0, 1, 0, 0);
    @(negedge clk);
    chk1("R3 cleared bit does not assert", irq_n, 1'b1);
    chk8("R6 no summary for cleared bit", rd_data, 8'h02);
    pulse(1, 0, 0, 0);
    @(negedge clk);
    chk1("R3 remaining bit asserts", irq_n, 1'b0);
    chk8("R6 summary with mixed flags", rd_data, 8'h83);
    do_read(v);
    chk1("R7 release after mixed", irq_n, 1'b1);
  endtask

  task automatic t_late_enable;
    logic [7:0] v;
    mask_write(8'h7F);
    pulse(0, 0, 0, 1);
    @(negedge clk);
    chk8("R2 edge flag pending", rd_data, 8'h10);
    chk1("R2 masked edge keeps line high", irq_n, 1'b1);
    mask_write(8'h90);
    chk1("R5 line high one edge after write", irq_n, 1'b1);
    @(negedge clk);
    chk1("R5 line low two edges after write", irq_n, 1'b0);
    do_read(v);
    chk8("R5 read value", v, 8'h90);
  endtask

  task automatic t_coincident;
    logic [7:0] v;
    mask_write(8'h7F);
    mask_write(8'h84);
    pulse(0, 0, 1, 0);
    @(negedge clk);
    chk1("R4 alarm asserts", irq_n, 1'b0);
    rd_stb = 1'b1; alarm_evt = 1'b1;
    #1 v = rd_data;
    chk8("R8 read value", v, 8'h84);
    @(negedge clk);
    rd_stb = 1'b0; alarm_evt = 1'b0;
    chk1("R8 read releases line", irq_n, 1'b1);
    chk8("R8 new event kept", rd_data, 8'h84);
    @(negedge clk);
    chk1("R8 new event re-asserts", irq_n, 1'b0);
    do_read(v);
    @(negedge clk);
    chk1("R8 final release", irq_n, 1'b1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0;
    tmr_a_evt = 0; tmr_b_evt = 0; alarm_evt = 0; edge_evt = 0;
    rd_stb = 0; wr_stb = 0; wr_data = 8'h00;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_unmasked();
    t_delay();
    t_cancel();
    t_same_rd_wr();
    t_mask_seq();
    t_late_enable();
    t_coincident();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule